// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one external interrupt-request pin and turns a chosen transition on it into a latched event flag and an interrupt line for the processor. The pin is first passed through a two-flop synchronizer. The block then looks for a falling edge or a rising edge, depending on the polarity setting. An optional level mode keeps the flag set for as long as the pin stays at its active level. Software acknowledges an event by writing a 1 to a write-only bit, and the interrupt output is the flag gated by an enable bit.

Everything is set through a single 8-bit control/status register on a plain processor bus, which has address, write strobe, read strobe, write data and read data. The block also drives a pull-enable output that tells the pad whether to switch on its internal pull resistor. The pad, the resistor and the interrupt vectoring are not part of this block.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00, `irq_out` is 0 and `pull_en` is 1.
- R2: Bit 7 and bit 2 always read as 0. A write of 1 to bit 7 is discarded. The writable bits are 6, 5, 4, 1 and 0, so writing 0xFF reads back as 0x73 while no event is pending.
- R3: A pin change is seen only after synchronization. If the pin changes before clock edge k, the flag (bit 3) and `irq_out` first show it after edge k+2.
- R4: With bit 5 = 0, only falling edges set the flag. With bit 5 = 1, only rising edges set it. An edge of the other direction leaves the flag at 0.
- R5: While bit 4 (pin enable) is 0, no pin activity sets the flag.
- R6: A write with bit 2 = 1 clears the flag. A write with bit 2 = 0 leaves the flag unchanged.
- R7: With bit 0 = 1 (edge-and-level mode), an acknowledge has no effect while the synchronized pin is at its active level. Once the pin has left that level, an acknowledge clears the flag.
- R8: If a qualifying edge and an acknowledge land in the same cycle, the flag ends up at 1.
- R9: `irq_out` is 1 exactly when the flag is 1 and bit 1 (interrupt enable) is 1.
- R10: When bit 4 = 1, `pull_en` = NOT bit 6 AND NOT bit 5, so rising polarity always turns the pull off. When bit 4 = 0, `pull_en` is 1.
- R11: If the pin function is enabled while the pin already sits at the level that follows an edge, no event is produced.
- R12: Reads and writes act only at address `REG_ADDR` (default 0). A write to any other address changes nothing, and `bus_rdata` is 0 unless a read strobe addresses the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when the register is not being read |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| irq_out | output | 1 | Interrupt request to the processor |
| pull_en | output | 1 | Request to the pad to enable its internal pull resistor |

## Verification
Falling and rising pin transitions are each driven under both polarity settings. This separates a detector that honours the polarity from one that fires on any toggle. The pin is also moved while the function is disabled, and the function is then re-enabled with the pin already low. These cases show whether the edge history is taken from live samples or from stale state. In level mode an acknowledge is issued once with the pin still held active and once after it has been released, which tells the level hold apart from ordinary edge clearing. An acknowledge is also placed in the exact cycle the edge lands, which exposes any wrong priority between set and clear.

// File: rtl/irq_pin_pkg.sv
// Package: shared bit positions, masks and the configuration record for
// the interrupt pin controller. Assumes an 8-bit register image.
package irq_pin_pkg;

    localparam int REG_W        = 8;
    localparam int BIT_PULL_OFF = 6;
    localparam int BIT_POL_HIGH = 5;
    localparam int BIT_PIN_EN   = 4;
    localparam int BIT_FLAG     = 3;
    localparam int BIT_ACK      = 2;
    localparam int BIT_INT_EN   = 1;
    localparam int BIT_LVL_MODE = 0;

    typedef struct packed {
        logic pull_off;
        logic pol_high;
        logic pin_en;
        logic int_en;
        logic lvl_mode;
    } irq_cfg_t;

endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Brings the asynchronous pin into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 1; every stage resets to 0.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single sampling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            // Shift the pin sample through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/irq_pin_detect.sv
// Module: irq_pin_detect
// Finds the selected edge on the synchronized pin and keeps the event
// flag. Set takes priority over acknowledge. In level mode, acknowledge
// is blocked while the pin sits at its active level. The previous-sample
// register always reloads from the live sample, so while the function is
// off the history follows the pin and re-enabling sees no stale edge.
module irq_pin_detect
    import irq_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s,
    input  irq_cfg_t cfg,
    input  logic     ack_pulse,
    output logic     flag
);

    logic prev_s;
    logic rise;
    logic fall;
    logic hit;
    logic active_lvl;
    logic hold;

    // Remember the last synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_s <= 1'b0;
        else        prev_s <= pin_s;
    end

    // Classify the current sample against history and the settings.
    always_comb begin
        rise       = pin_s & ~prev_s;
        fall       = ~pin_s & prev_s;
        hit        = cfg.pin_en & (cfg.pol_high ? rise : fall);
        active_lvl = cfg.pin_en & (pin_s == cfg.pol_high);
        hold       = cfg.lvl_mode & active_lvl;
    end

    // Event flag: set wins, acknowledge clears unless the level holds it.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (hit)              flag <= 1'b1;
        else if (ack_pulse && !hold) flag <= 1'b0;
    end

    p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.pin_en && !flag) |=> !flag);

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !hit && !hold) |=> !flag);

    p_level_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && hold) |=> flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ack_pulse) |=> flag);

endmodule

// File: rtl/irq_pin_regs.sv
// Module: irq_pin_regs
// Holds the control bits of the register, builds the read image and
// turns a write of 1 to the acknowledge bit into a one-cycle pulse.
// Assumes single-cycle bus strobes; read data is combinational.
module irq_pin_regs
    import irq_pin_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              flag,
    output logic [REG_W-1:0]  bus_rdata,
    output irq_cfg_t          cfg,
    output logic              ack_pulse
);

    logic             sel;
    logic [REG_W-1:0] image;

    assign sel       = (bus_addr == REG_ADDR);
    assign ack_pulse = bus_we & sel & bus_wdata[BIT_ACK];

    // Capture the writable control fields on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (bus_we && sel) begin
            cfg.pull_off <= bus_wdata[BIT_PULL_OFF];
            cfg.pol_high <= bus_wdata[BIT_POL_HIGH];
            cfg.pin_en   <= bus_wdata[BIT_PIN_EN];
            cfg.int_en   <= bus_wdata[BIT_INT_EN];
            cfg.lvl_mode <= bus_wdata[BIT_LVL_MODE];
        end
    end

    // Assemble the read image; reserved and acknowledge bits stay 0.
    always_comb begin
        image               = '0;
        image[BIT_PULL_OFF] = cfg.pull_off;
        image[BIT_POL_HIGH] = cfg.pol_high;
        image[BIT_PIN_EN]   = cfg.pin_en;
        image[BIT_FLAG]     = flag;
        image[BIT_INT_EN]   = cfg.int_en;
        image[BIT_LVL_MODE] = cfg.lvl_mode;
        bus_rdata           = (bus_re && sel) ? image : '0;
    end

    p_rsvd_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> (bus_rdata[7] == 1'b0 && bus_rdata[BIT_ACK] == 1'b0));

    p_idle_bus_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

endmodule

// File: rtl/irq_pin_ctrl.sv
// Module: irq_pin_ctrl (top)
// External interrupt pin controller: synchronizer, edge/level detector
// and register. Drives the interrupt and the pad pull request. Assumes
// the pin is asynchronous and the bus is synchronous to clk.
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int                ADDR_W        = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR      = '0,
    parameter int                SYNC_STAGES   = 2,
    parameter logic              PULL_WHEN_OFF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pin_in,
    output logic              irq_out,
    output logic              pull_en
);

    irq_cfg_t cfg;
    logic     ack_pulse;
    logic     flag;
    logic     pin_s;

    irq_pin_regs #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .ack_pulse (ack_pulse)
    );

    irq_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_s)
    );

    irq_pin_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s),
        .cfg       (cfg),
        .ack_pulse (ack_pulse),
        .flag      (flag)
    );

    // Outputs: gated interrupt and pad pull request.
    always_comb begin
        irq_out = flag & cfg.int_en;
        pull_en = cfg.pin_en ? (~cfg.pull_off & ~cfg.pol_high) : PULL_WHEN_OFF;
    end

    p_rising_pull_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pin_en && cfg.pol_high) |-> !pull_en);

endmodule

// File: tb/irq_pin_ctrl_bench.sv
// Bench: behavioural reference model updated on every clock and compared
// against the design one nanosecond after each rising edge, plus directed
// checks with hand-derived values.
module irq_pin_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_in = 1'b1;
    logic       irq_out;
    logic       pull_en;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [7:0] m_reg = '0;
    logic       m_flag = 1'b0;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;

    always #2 clk = ~clk;

    irq_pin_ctrl u_irq_pin_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out),
        .pull_en   (pull_en)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model step at each edge, then compare outputs shortly after.
    always @(posedge clk) begin
        logic hit, hold, ack, wr;
        if (!rst_n) begin
            m_reg = '0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            wr   = bus_we && (bus_addr == 4'd0);
            ack  = wr && bus_wdata[2];
            hit  = m_reg[4] && (m_reg[5] ? (m_s2 && !m_prev) : (!m_s2 && m_prev));
            hold = m_reg[0] && m_reg[4] && (m_s2 == m_reg[5]);
            if (hit) m_flag = 1;
            else if (ack && !hold) m_flag = 0;
            if (wr) m_reg = bus_wdata & 8'h73;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
        #1;
        chk({7'd0, irq_out}, {7'd0, m_flag & m_reg[1]}, cur_req, "irq_out model");
        chk({7'd0, pull_en}, {7'd0, m_reg[4] ? (!m_reg[6] && !m_reg[5]) : 1'b1}, cur_req, "pull_en model");
        chk(bus_rdata, (bus_re && bus_addr == 4'd0) ? (m_reg | {4'd0, m_flag, 3'd0}) : 8'h00,
            cur_req, "rdata model");
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); bus_re = 1; bus_addr = a;
        #1 chk(bus_rdata, exp, req, "read");
        bus_re = 0; bus_addr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input logic v);
        @(negedge clk); pin_in = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(4); rst_n = 1; idle(3);
        cur_req = "R1";
        rd(4'd0, 8'h00, "R1");
        chk({7'd0, pull_en}, 8'h01, "R1", "pull_en after reset");
        chk({7'd0, irq_out}, 8'h00, "R1", "irq after reset");

        // R2: reserved and acknowledge bits read 0
        cur_req = "R2";
        wr(4'd0, 8'hFF); rd(4'd0, 8'h73, "R2");
        wr(4'd0, 8'h00); idle(4);

        // R12: other address ignored
        cur_req = "R12";
        wr(4'd1, 8'h12); rd(4'd0, 8'h00, "R12"); rd(4'd1, 8'h00, "R12");

        // R3/R4/R9: falling edge, exact latency
        cur_req = "R3";
        wr(4'd0, 8'h12); idle(2);
        @(negedge clk); pin_in = 0;
        @(posedge clk); #1 chk({7'd0, irq_out}, 8'h00, "R3", "irq after edge+0");
        @(posedge clk); #1 chk({7'd0, irq_out}, 8'h00, "R3", "irq after edge+1");
        @(posedge clk); #1 chk({7'd0, irq_out}, 8'h01, "R3", "irq after edge+2");
        cur_req = "R9";
        rd(4'd0, 8'h1A, "R9");
        wr(4'd0, 8'h10); chk({7'd0, irq_out}, 8'h00, "R9", "irq masked");
        rd(4'd0, 8'h18, "R9");

        // R6: acknowledge and zero write
        cur_req = "R6";
        wr(4'd0, 8'h16); rd(4'd0, 8'h12, "R6");
        setpin(1); idle(4); setpin(0); idle(4);
        wr(4'd0, 8'h12); rd(4'd0, 8'h1A, "R6");
        wr(4'd0, 8'h16); rd(4'd0, 8'h12, "R6");

        // R4: rising edge ignored in falling mode; then rising mode
        cur_req = "R4";
        setpin(1); idle(4); rd(4'd0, 8'h12, "R4");
        wr(4'd0, 8'h32); setpin(0); idle(4); rd(4'd0, 8'h32, "R4");
        setpin(1); idle(4); rd(4'd0, 8'h3A, "R4");
        wr(4'd0, 8'h36); rd(4'd0, 8'h32, "R4");

        // R10: pull request gating
        cur_req = "R10";
        wr(4'd0, 8'h12); chk({7'd0, pull_en}, 8'h01, "R10", "pull on");
        wr(4'd0, 8'h52); chk({7'd0, pull_en}, 8'h00, "R10", "pull disabled");
        wr(4'd0, 8'h32); chk({7'd0, pull_en}, 8'h00, "R10", "rising forces off");
        wr(4'd0, 8'h62); chk({7'd0, pull_en}, 8'h01, "R10", "pin off");

        // R5: disabled pin produces no events
        cur_req = "R5";
        wr(4'd0, 8'h02); setpin(0); idle(4); setpin(1); idle(4); setpin(0); idle(4);
        rd(4'd0, 8'h02, "R5");

        // R11: enable while pin already low, no spurious event
        cur_req = "R11";
        wr(4'd0, 8'h12); idle(5); rd(4'd0, 8'h12, "R11");

        // R7: level mode blocks acknowledge while pin is low
        cur_req = "R7";
        wr(4'd0, 8'h13); setpin(1); idle(4); setpin(0); idle(4);
        rd(4'd0, 8'h1B, "R7");
        wr(4'd0, 8'h17); rd(4'd0, 8'h1B, "R7");
        setpin(1); idle(4);
        wr(4'd0, 8'h17); rd(4'd0, 8'h13, "R7");

        // R8: edge and acknowledge in the same cycle
        cur_req = "R8";
        wr(4'd0, 8'h12); idle(2);
        @(negedge clk); pin_in = 0;
        @(negedge clk);
        @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 8'h16;
        @(negedge clk); bus_we = 0; bus_wdata = 0;
        rd(4'd0, 8'h1A, "R8");
        chk({7'd0, irq_out}, 8'h01, "R8", "irq after set+ack");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule